// File: doc/BRIEF.md
# NAND Page Sector Layout Sequencer

This block walks a byte stream through the layout of one NAND page. A page is a run of equal sectors, and each sector holds three regions in a fixed order: 512 bytes of main data, an 8-byte free-data field, and a parity field that fills the rest of the sector's spare area. The byte stream passes through unchanged. Each byte that leaves carries a region tag, its offset inside that region and a flag on the final byte of the page. Downstream logic can therefore route data, free bytes and parity without counting bytes itself.

Software picks the page size and the spare size per sector with two 2-bit codes and pulses start. The sequencer stays busy until the last parity byte of the last sector is accepted. The completed-sector counter then equals the page's sector count and done goes high. Both stream sides use valid/ready. A byte moves only in a cycle where the producer's valid and the consumer's ready are both high. Back-pressure is passed straight through: input ready follows output ready while busy. When idle, ready and valid are both held low. A flush input drops any page in flight and returns the block to idle.

Top module: `nand_sector_seq`

## Requirements
- R1: After reset, busy, done, err, sect_cnt and in_ready are 0 and out_region is idle (code 0).
- R2: A start pulse while idle, with page_code 0, 1 or 2, selects 1, 4 or 8 sectors (512, 2048 or 4096 bytes of data). In the next cycle busy is 1, sect_cnt is 0, out_region is data (code 1) and out_offset is 0.
- R3: Within every sector the region tags run in this order. Data (code 1) has offsets 0 to 511. Free data (code 2) has offsets 0 to 7. Parity (code 3) has offsets 0 to P-1, where P is the spare size minus 8 and spare_code 0, 1, 2, 3 gives a spare size of 16, 26, 27, 28. No reordering happens across sectors.
- R4: A byte is transferred only when in_valid and in_ready are both high. While busy, in_ready equals out_ready, out_valid equals in_valid and out_data equals in_data. A stalled cycle leaves region and offset unchanged.
- R5: sect_cnt holds the number of completed sectors and steps by one when the last parity byte of a sector is accepted. out_last is high exactly on the final byte of the page.
- R6: In the cycle after the final byte, busy is 0, done is 1 and sect_cnt equals the page's sector count. These values hold until the next accepted start or a flush.
- R7: A start with page_code 3 (reserved) sets err and does not start a page. The next accepted start clears err.
- R8: A start while busy is ignored. The page in flight continues with its original codes.
- R9: A flush pulse returns the block to the R1 state in the next cycle, even in the middle of a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous clear to idle |
| start | input | 1 | Start pulse, taken only while idle |
| page_code | input | 2 | Page size: 0=512, 1=2048, 2=4096, 3 reserved |
| spare_code | input | 2 | Spare per sector: 0=16, 1=26, 2=27, 3=28 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 8 | Output byte |
| out_region | output | 2 | 0 idle, 1 data, 2 free data, 3 parity |
| out_offset | output | 9 | Byte offset within the region |
| out_last | output | 1 | Final byte of the page |
| busy | output | 1 | Page in progress |
| done | output | 1 | Page completed |
| err | output | 1 | Reserved page code was requested |
| sect_cnt | output | 4 | Completed sectors |

## Verification
The hardest case to reach is a start request that arrives in the middle of a page with different codes. If it were wrongly accepted, it would silently rewrite the layout. The stimulus raises start with the 4096-byte code and the largest spare code at byte 100 of a single-sector page. It then checks that every later byte still follows the original layout and that done arrives after exactly one sector. Flush in the middle of the second sector is reached by streaming 600 bytes first. Independent valid and ready gaps, at periods of 5 and 7 cycles, exercise stalls at the region boundaries.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
  typedef enum logic [1:0] {
    RG_IDLE = 2'd0,
    RG_DATA = 2'd1,
    RG_FDM  = 2'd2,
    RG_PAR  = 2'd3
  } region_e;

  function automatic int unsigned page_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 512;
      2'd1:    return 2048;
      2'd2:    return 4096;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned spare_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 26;
      2'd2:    return 27;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/nsq_cfg_decode.sv
module nsq_cfg_decode #(
  parameter int SECTOR_BYTES = 512,
  parameter int FDM_BYTES    = 8,
  parameter int CNT_W        = 4,
  parameter int OFF_W        = 9
) (
  input  logic [1:0]       page_code,
  input  logic [1:0]       spare_code,
  output logic [CNT_W-1:0] nsect,
  output logic [OFF_W-1:0] par_len,
  output logic             reserved
);
  import nsq_pkg::*;

  always_comb begin
    nsect    = CNT_W'(page_bytes(page_code) / SECTOR_BYTES);
    par_len  = OFF_W'(spare_bytes(spare_code) - FDM_BYTES);
    reserved = (page_code == 2'd3);
  end
endmodule

// File: rtl/nsq_region_walker.sv
module nsq_region_walker #(
  parameter int SECTOR_BYTES = 512,
  parameter int FDM_BYTES    = 8,
  parameter int OFF_W        = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                go,
  input  logic                beat,
  input  logic [OFF_W-1:0]    par_len,
  output nsq_pkg::region_e    region,
  output logic [OFF_W-1:0]    offset,
  output logic                sect_last
);
  import nsq_pkg::*;

  localparam logic [OFF_W-1:0] DATA_LAST = OFF_W'(SECTOR_BYTES - 1);
  localparam logic [OFF_W-1:0] FDM_LAST  = OFF_W'(FDM_BYTES - 1);

  logic at_last;

  always_comb begin
    case (region)
      RG_DATA: at_last = (offset == DATA_LAST);
      RG_FDM:  at_last = (offset == FDM_LAST);
      RG_PAR:  at_last = (offset == par_len - OFF_W'(1));
      default: at_last = 1'b0;
    endcase
    sect_last = at_last && (region == RG_PAR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      region <= RG_IDLE;
      offset <= '0;
    end else if (go) begin
      region <= RG_DATA;
      offset <= '0;
    end else if (beat) begin
      if (at_last) begin
        offset <= '0;
        case (region)
          RG_DATA: region <= RG_FDM;
          RG_FDM:  region <= RG_PAR;
          RG_PAR:  region <= RG_DATA;
          default: region <= RG_IDLE;
        endcase
      end else begin
        offset <= offset + OFF_W'(1);
      end
    end
  end
endmodule

// File: rtl/nsq_sector_count.sv
module nsq_sector_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             go,
  input  logic             incr,
  input  logic [CNT_W-1:0] nsect_in,
  output logic [CNT_W-1:0] cnt,
  output logic             on_final
);
  logic [CNT_W-1:0] nsect_q;

  assign on_final = (cnt + CNT_W'(1) == nsect_q);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt     <= '0;
      nsect_q <= '0;
    end else if (go) begin
      cnt     <= '0;
      nsect_q <= nsect_in;
    end else if (incr) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/nand_sector_seq.sv
module nand_sector_seq #(
  parameter int SECTOR_BYTES = 512,
  parameter int FDM_BYTES    = 8,
  parameter int MAX_SECT     = 8,
  parameter int DATA_W       = 8,
  localparam int OFF_W       = $clog2(SECTOR_BYTES),
  localparam int CNT_W       = $clog2(MAX_SECT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              start,
  input  logic [1:0]        page_code,
  input  logic [1:0]        spare_code,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        out_region,
  output logic [OFF_W-1:0]  out_offset,
  output logic              out_last,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [CNT_W-1:0]  sect_cnt
);
  import nsq_pkg::*;

  logic [CNT_W-1:0] dec_nsect;
  logic [OFF_W-1:0] dec_par, par_q;
  logic             dec_resv, go, bad, beat, sect_last, on_final, page_end;
  region_e          region;

  nsq_cfg_decode #(
    .SECTOR_BYTES(SECTOR_BYTES), .FDM_BYTES(FDM_BYTES),
    .CNT_W(CNT_W), .OFF_W(OFF_W)
  ) u_dec (
    .page_code(page_code), .spare_code(spare_code),
    .nsect(dec_nsect), .par_len(dec_par), .reserved(dec_resv)
  );

  assign go       = start && !busy && !dec_resv;
  assign bad      = start && !busy && dec_resv;
  assign beat     = busy && in_valid && out_ready;
  assign out_last = busy && sect_last && on_final;
  assign page_end = beat && out_last;

  nsq_region_walker #(
    .SECTOR_BYTES(SECTOR_BYTES), .FDM_BYTES(FDM_BYTES), .OFF_W(OFF_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(flush || page_end), .go(go),
    .beat(beat), .par_len(par_q), .region(region), .offset(out_offset),
    .sect_last(sect_last)
  );

  nsq_sector_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .flush(flush), .go(go),
    .incr(beat && sect_last), .nsect_in(dec_nsect),
    .cnt(sect_cnt), .on_final(on_final)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      par_q <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      err   <= 1'b0;
      par_q <= dec_par;
    end else if (bad) begin
      err <= 1'b1;
    end else if (page_end) begin
      busy <= 1'b0;
      done <= 1'b1;
    end
  end

  assign in_ready   = busy && out_ready;
  assign out_valid  = busy && in_valid;
  assign out_data   = in_data;
  assign out_region = region;
endmodule

// File: rtl/nsq_checker.sv
module nsq_checker #(
  parameter int SECTOR_BYTES = 512,
  parameter int FDM_BYTES    = 8,
  parameter int OFF_W        = 9,
  parameter int CNT_W        = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             start,
  input logic [1:0]       page_code,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [1:0]       out_region,
  input logic [OFF_W-1:0] out_offset,
  input logic             out_last,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [CNT_W-1:0] sect_cnt
);
  logic xfer;
  assign xfer = in_valid && in_ready;

  a_r4_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !out_valid));

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer && !flush) |=> ($stable(out_region) && $stable(out_offset)));

  a_r3_fdm_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_region == 2'd2) |-> (out_offset < OFF_W'(FDM_BYTES)));

  a_r3_data_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !flush && out_region == 2'd1 && out_offset < OFF_W'(SECTOR_BYTES - 1))
    |=> (out_region == 2'd1 && out_offset == $past(out_offset) + OFF_W'(1)));

  a_r5_cnt_only_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush && !(xfer && out_region == 2'd3)) |=> $stable(sect_cnt));

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r7_reserved_err: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !flush && page_code == 2'd3) |=> (err && !busy));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush && !(xfer && out_last)) |=> busy);

  a_r9_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!busy && !done && !err && sect_cnt == '0 && out_region == 2'd0));
endmodule

bind nand_sector_seq nsq_checker #(
  .SECTOR_BYTES(SECTOR_BYTES), .FDM_BYTES(FDM_BYTES),
  .OFF_W(OFF_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .start(start),
  .page_code(page_code), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_region(out_region), .out_offset(out_offset),
  .out_last(out_last), .busy(busy), .done(done), .err(err),
  .sect_cnt(sect_cnt)
);

// File: tb/tb_nand_sector_seq.sv
`timescale 1ns/1ps
module tb_nand_sector_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, start = 1'b0;
  logic [1:0] page_code = '0, spare_code = '0;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_last, busy, done, err;
  logic [7:0] out_data;
  logic [1:0] out_region;
  logic [8:0] out_offset;
  logic [3:0] sect_cnt;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  nand_sector_seq dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .start(start),
    .page_code(page_code), .spare_code(spare_code),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_region(out_region), .out_offset(out_offset), .out_last(out_last),
    .busy(busy), .done(done), .err(err), .sect_cnt(sect_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sectors_of(input int pc);
    return (pc == 0) ? 1 : (pc == 1) ? 4 : 8;
  endfunction

  function automatic int parity_of(input int sc);
    return (sc == 0) ? 8 : (sc == 1) ? 18 : (sc == 2) ? 19 : 20;
  endfunction

  task automatic idle_check(input string req);
    check(busy == 0 && done == 0 && err == 0, {req, " flags"}, {busy, done, err}, 0);
    check(sect_cnt == 0 && out_region == 0, {req, " cnt/region"}, {sect_cnt, out_region}, 0);
    check(in_ready == 0, {req, " in_ready"}, in_ready, 0);
  endtask

  // streams 'limit' bytes (or whole page when limit<0)
  task automatic stream(input int pc, input int sc, input bit bp, input int poke_at,
                        input int limit);
    int ns = sectors_of(pc), par = parity_of(sc);
    int spb = 512 + 8 + par, total = ns * spb, k = 0, cyc = 0;
    int stop = (limit < 0) ? total : limit;
    @(negedge clk); page_code = 2'(pc); spare_code = 2'(sc); start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    check(busy == 1 && sect_cnt == 0 && out_region == 1 && out_offset == 0,
          "R2 start state", {busy, out_region}, 5);
    while (k < stop) begin
      int sec, r, exp_rg, exp_off;
      in_valid  = !(bp && (cyc % 5 == 3));
      out_ready = !(bp && (cyc % 7 == 2));
      in_data   = 8'(k) ^ 8'h5A;
      if (k == poke_at) begin start = 1'b1; page_code = 2'd2; spare_code = 2'd3; end
      else start = 1'b0;
      #1;
      check(in_ready == out_ready && out_valid == in_valid && out_data == in_data,
            "R4 handshake pass-through", {in_ready, out_valid}, {out_ready, in_valid});
      if (in_valid && in_ready) begin
        sec = k / spb; r = k % spb;
        if (r < 512) begin exp_rg = 1; exp_off = r; end
        else if (r < 520) begin exp_rg = 2; exp_off = r - 512; end
        else begin exp_rg = 3; exp_off = r - 520; end
        check(out_region == exp_rg && out_offset == exp_off,
              "R3 region/offset", out_region * 1000 + out_offset, exp_rg * 1000 + exp_off);
        check(sect_cnt == sec && out_last == (k == total - 1),
              "R5 count/last", sect_cnt * 2 + out_last, sec * 2 + (k == total - 1));
        k++;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0;
    page_code = 2'(pc); spare_code = 2'(sc);
    #1;
    if (limit < 0) begin
      check(busy == 0 && done == 1 && sect_cnt == ns, "R6 completion",
            {busy, done} * 16 + sect_cnt, 16 + ns);
      repeat (3) @(negedge clk);
      #1;
      check(done == 1 && busy == 0 && sect_cnt == ns, "R6 done holds", done, 1);
    end
  endtask

  task automatic t_reset;
    #1; idle_check("R1 reset");
  endtask

  task automatic t_reserved;
    @(negedge clk); page_code = 2'd3; start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    check(err == 1 && busy == 0 && out_region == 0, "R7 reserved sets err", {err, busy}, 2);
    @(negedge clk); page_code = 2'd0; start = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    check(err == 0 && busy == 1, "R7 err cleared by start", {err, busy}, 1);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0; #1;
    idle_check("R9 flush after R7");
  endtask

  task automatic t_flush_mid;
    stream(1, 1, 1'b0, -1, 600);
    check(sect_cnt == 1 && busy == 1, "R9 pre-flush progress", sect_cnt, 1);
    flush = 1'b1;
    @(negedge clk); flush = 1'b0; #1;
    idle_check("R9 mid-page flush");
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    stream(0, 0, 1'b0, -1, -1);     // 1 sector, spare 16
    stream(1, 1, 1'b1, -1, -1);     // 4 sectors, spare 26, back-pressure
    stream(2, 3, 1'b0, -1, -1);     // 8 sectors, spare 28
    stream(0, 2, 1'b1, 100, -1);    // R8: start poked while busy, spare 27
    t_reserved();
    t_flush_mid();
    stream(1, 0, 1'b0, -1, -1);     // full page after flush
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule